// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block receives 8N1 serial frames. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit; the line rests high between frames. The line runs at 250 kHz. The receiver looks at it once per pulse of `sample_en`, which is a one-clock enable at 2 MHz, eight times the bit rate, derived from a faster system clock. The serial input first passes through a two-stage synchronizer. All timing inside a frame then comes from one sample counter.

The counter is cleared and held while the receiver is idle. A low sample on the idle line starts it. Half a bit later a self-holding commit flag is set if the line is still low. If the line has gone high again, the frame is dropped as a glitch. While the flag is set, the line is shifted into a byte register each time the low three counter bits equal 3'b011, which is close to mid-bit. At count 75 (nine bits of eight samples, plus three) the byte is published and a data-ready flag is raised for one sample period. The stop bit is never shifted in. The counter, the flag and the frame state are then cleared.

Top module: `oversampled_uart_rx`

## Requirements
- R1: `rst_n` is an asynchronous active-low reset. While it is low and after it is released, `rx_ready` is 0, `rx_data` is 8'h00 and the receiver is idle.
- R2: `rx_serial` passes through two `clk` register stages before any sample tick can see it, so a change on the pin is visible to a tick no earlier than the third rising edge after the change.
- R3: On a tick while idle, a low synchronized line starts a frame. Every frame that completes gives exactly one `rx_ready` pulse.
- R4: On the fifth tick of a frame (counter value 4), a high line abandons the frame: no ready pulse, and `rx_data` is left unchanged. A low line commits the frame.
- R5: Data bit k (k = 0..7) is sampled on the tick at counter value 8k+11, where the low three bits are 3'b011. The first data bit received ends up in `rx_data[0]` and the last in `rx_data[7]`.
- R6: `rx_ready` rises on the tick that brings the counter to 75 and falls on the next tick. With one tick every four clocks it is high for four clocks.
- R7: `rx_data` changes only on the edge where `rx_ready` rises, and holds its value until the next frame completes.
- R8: After a frame completes, the receiver is idle from the following tick. A start bit that directly follows a one-bit stop bit is received as a new frame.
- R9: While `sample_en` is low, the counter, the frame state and the commit flag are frozen. Line activity that falls entirely between ticks is never seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-clock sample tick at 8x the bit rate |
| rx_serial | input | 1 | Serial line, idle high |
| rx_data | output | 8 | Last received byte, D0 in bit 0 |
| rx_ready | output | 1 | High for one sample period when a byte completes |

## Verification
Two functions can fall on the same tick. The clear at frame completion (count 75, then idle) lands just before the next start bit when frames are sent back to back with a single stop bit. The glitch decision at count 4 can land on the same tick as a line edge. Back-to-back streams are sent at several clock phase offsets. Low pulses of two ticks and seven ticks test both sides of the commit decision. A behavioural model of the frame timing compares ready and data against the design on every clock, and a second monitor compares each published byte with the byte that was sent.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Frame state of the receiver.
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // Count at which a frame is complete: start plus data bits, each osr
  // samples long, plus the mid-bit phase offset, so the stop bit is never
  // captured.
  function automatic int frame_end_count(input int data_w, input int osr);
    return (data_w + 1) * osr + osr / 2 - 1;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  // STAGES must be at least 2.
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{IDLE_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame_ctrl.sv
module uart_rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR       = 8,
  parameter int END_COUNT = 75,
  parameter int CNT_W     = 7,
  parameter int PHASE_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             line,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active,
  output logic             proceed_q,
  output logic             frame_done,
  output logic             capture,
  output logic             publish
);

  localparam logic [CNT_W-1:0]   END_VAL  = CNT_W'(END_COUNT);
  localparam logic [CNT_W-1:0]   LAST_VAL = CNT_W'(END_COUNT - 1);
  localparam logic [PHASE_W-1:0] CAPT_PH  = PHASE_W'(OSR / 2 - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             proceed_d;
  logic             cnt_en;
  logic             half_bit;
  logic             abandon;
  logic             cnt_clr;

  always_comb begin
    cnt_en     = (state_q == RX_BUSY);
    frame_done = (cnt_q == END_VAL);
    half_bit   = cnt_q[PHASE_W-1];
    abandon    = cnt_en && !proceed_q && half_bit && line;
    cnt_clr    = !cnt_en || frame_done || abandon;

    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_clr) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end

    // Self-holding commit flag, forced low by frame completion.
    proceed_d = proceed_q;
    if (tick) begin
      proceed_d = !frame_done && (proceed_q || (cnt_en && half_bit && !line));
    end

    state_d = state_q;
    if (tick) begin
      if (!cnt_en && !line)                    state_d = RX_BUSY;
      else if (cnt_en && (frame_done || abandon)) state_d = RX_IDLE;
    end

    capture = tick && proceed_q && !frame_done && (cnt_q[PHASE_W-1:0] == CAPT_PH);
    publish = tick && proceed_q && (cnt_q == LAST_VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      proceed_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      proceed_q <= proceed_d;
    end
  end

  assign active = (state_q == RX_BUSY);

endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              publish,
  input  logic              line,
  output logic [DATA_W-1:0] byte_q
);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] byte_d;

  always_comb begin
    shreg_d = shreg_q;
    if (capture) shreg_d = {line, shreg_q[DATA_W-1:1]};
    byte_d = byte_q;
    if (publish) byte_d = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      byte_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      byte_q  <= byte_d;
    end
  end

endmodule

// File: rtl/oversampled_uart_rx.sv
module oversampled_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              rx_serial,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready
);

  localparam int PHASE_W   = $clog2(OSR);
  localparam int END_COUNT = uart_rx_pkg::frame_end_count(DATA_W, OSR);
  localparam int CNT_W     = $clog2(END_COUNT + 1);

  logic             line_s;
  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             proceed_q;
  logic             capture;
  logic             publish;

  uart_rx_sync #(
    .STAGES   (SYNC_STAGES),
    .IDLE_VAL (1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (line_s)
  );

  uart_rx_frame_ctrl #(
    .OSR      (OSR),
    .END_COUNT(END_COUNT),
    .CNT_W    (CNT_W),
    .PHASE_W  (PHASE_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_en),
    .line      (line_s),
    .cnt_q     (cnt_q),
    .active    (active),
    .proceed_q (proceed_q),
    .frame_done(rx_ready),
    .capture   (capture),
    .publish   (publish)
  );

  uart_rx_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .publish(publish),
    .line   (line_s),
    .byte_q (rx_data)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DATA_W    = 8,
  parameter int OSR       = 8,
  parameter int CNT_W     = 7,
  parameter int END_COUNT = 75
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_en,
  input logic              line,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic [CNT_W-1:0]  cnt,
  input logic              active,
  input logic              proceed
);

  localparam logic [CNT_W-1:0] HALF_VAL = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] END_VAL  = CNT_W'(END_COUNT);

  AST_RDY_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !sample_en) |=> rx_ready); // R6
  AST_RDY_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && sample_en) |=> !rx_ready); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= END_VAL); // R6
  AST_DATA_ONLY_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $rose(rx_ready)); // R7
  AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(cnt) && $stable(active) && $stable(proceed))); // R9
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (cnt == '0)); // R8
  AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && sample_en) |=> (!active && !proceed)); // R8
  AST_COMMIT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    proceed |-> active); // R4
  AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !proceed && cnt == HALF_VAL && sample_en && line) |=> !active); // R4

endmodule

bind oversampled_uart_rx uart_rx_checker #(
  .DATA_W   (DATA_W),
  .OSR      (OSR),
  .CNT_W    (CNT_W),
  .END_COUNT(END_COUNT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample_en(sample_en),
  .line     (line_s),
  .rx_data  (rx_data),
  .rx_ready (rx_ready),
  .cnt      (cnt_q),
  .active   (active),
  .proceed  (proceed_q)
);

// File: tb/oversampled_uart_rx_tb.sv
`timescale 1ns/1ps
module oversampled_uart_rx_tb;

  localparam int DATA_W   = 8;
  localparam int OSR      = 8;
  localparam int TICK_CLK = 4;
  localparam int BIT_CLK  = OSR * TICK_CLK;
  localparam int END_POS  = (DATA_W + 1) * OSR + OSR / 2 - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_en = 1'b0;
  logic              rx_serial = 1'b1;
  logic              tick_gate = 1'b1;
  logic [1:0]        div = 2'd0;
  logic [DATA_W-1:0] rx_data;
  logic              rx_ready;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  oversampled_uart_rx u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .rx_serial(rx_serial),
    .rx_data  (rx_data),
    .rx_ready (rx_ready)
  );

  always @(negedge clk) begin
    div       <= div + 2'd1;
    sample_en <= tick_gate && (div == 2'd3);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: two-stage pipe, then an integer frame position.
  int                pos = -1;
  int                nbits = 0;
  logic              m0 = 1'b1, m1 = 1'b1, ln = 1'b1;
  logic [DATA_W-1:0] acc = '0;
  logic [DATA_W-1:0] exp_byte = '0;
  logic              exp_rdy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = -1; nbits = 0; m0 = 1'b1; m1 = 1'b1; acc = '0; exp_byte = '0;
    end else begin
      ln = m1; m1 = m0; m0 = rx_serial;
      if (sample_en) begin
        if (pos < 0) begin
          if (!ln) begin pos = 0; nbits = 0; end
        end else if (pos == END_POS) begin
          pos = -1;
        end else if (pos == OSR / 2 && ln) begin
          pos = -1;
        end else begin
          if (pos >= OSR + OSR / 2 - 1 && (pos % OSR) == OSR / 2 - 1 && nbits < DATA_W) begin
            acc[nbits] = ln;
            nbits++;
          end
          if (pos == END_POS - 1) exp_byte = acc;
          pos++;
        end
      end
    end
  end
  assign exp_rdy = (pos == END_POS);

  // Lockstep comparison and frame monitor.
  logic [DATA_W-1:0] sent_q[$];
  logic              prev_rdy = 1'b0;
  int                pulses = 0;
  int                width = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(rx_ready === exp_rdy, "R2 R6 model ready", int'(rx_ready), int'(exp_rdy));
      check(rx_data === exp_byte, "R5 R7 model data", int'(rx_data), int'(exp_byte));
      if (rx_ready && !prev_rdy) begin
        pulses++;
        if (sent_q.size() > 0) begin
          logic [DATA_W-1:0] e;
          e = sent_q.pop_front();
          check(rx_data === e, "R5 byte order", int'(rx_data), int'(e));
        end else begin
          check(1'b0, "R3 unexpected frame", int'(rx_data), 0);
        end
      end
      if (rx_ready) width++;
      if (!rx_ready && prev_rdy) begin
        check(width == TICK_CLK, "R6 ready width", width, TICK_CLK);
        width = 0;
      end
    end
    prev_rdy = rx_ready;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] b, input int gap);
    sent_q.push_back(b);
    rx_serial = 1'b0;
    wait_clk(BIT_CLK);
    for (int i = 0; i < DATA_W; i++) begin
      rx_serial = b[i];
      wait_clk(BIT_CLK);
    end
    rx_serial = 1'b1;
    wait_clk(BIT_CLK + gap);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    int p0;
    wait_clk(6);
    check(rx_ready == 1'b0, "R1 reset ready", int'(rx_ready), 0);
    check(rx_data == '0, "R1 reset data", int'(rx_data), 0);
    rst_n = 1'b1;
    wait_clk(20);
    check(rx_ready == 1'b0 && rx_data == '0, "R1 after release", int'(rx_data), 0);

    // Several patterns and phase offsets, last ones back to back (R3 R8).
    send_byte(8'h55, 41);
    send_byte(8'hA3, 7);
    send_byte(8'h00, 13);
    send_byte(8'hFF, 0);
    send_byte(8'h01, 0);
    send_byte(8'h80, 50);
    wait_clk(100);
    check(pulses == 6, "R3 one pulse per frame", pulses, 6);
    check(sent_q.size() == 0, "R8 back-to-back all received", sent_q.size(), 0);

    // Short glitch: two ticks low, dropped (R4).
    p0 = pulses;
    rx_serial = 1'b0; wait_clk(2 * TICK_CLK);
    rx_serial = 1'b1; wait_clk(500);
    check(pulses == p0, "R4 glitch dropped", pulses, p0);
    check(rx_data == 8'h80, "R7 data held after glitch", int'(rx_data), 8'h80);

    // Seven ticks low: committed, data bits read high (R4).
    sent_q.push_back(8'hFF);
    rx_serial = 1'b0; wait_clk(7 * TICK_CLK);
    rx_serial = 1'b1; wait_clk(400);
    check(pulses == p0 + 1, "R4 long low committed", pulses, p0 + 1);
    check(rx_data == 8'hFF, "R4 committed data", int'(rx_data), 8'hFF);

    // Line activity with ticks stopped is never seen (R9).
    p0 = pulses;
    tick_gate = 1'b0; wait_clk(8);
    rx_serial = 1'b0; wait_clk(40);
    rx_serial = 1'b1; wait_clk(8);
    tick_gate = 1'b1; wait_clk(400);
    check(pulses == p0, "R9 no ticks no frame", pulses, p0);

    // Reset in the middle of a frame (R1).
    rx_serial = 1'b0; wait_clk(BIT_CLK + 3 * BIT_CLK);
    rst_n = 1'b0; wait_clk(2);
    check(rx_ready == 1'b0, "R1 mid-frame reset ready", int'(rx_ready), 0);
    check(rx_data == '0, "R1 mid-frame reset data", int'(rx_data), 0);
    rx_serial = 1'b1; wait_clk(4);
    rst_n = 1'b1; wait_clk(60);
    p0 = pulses;
    send_byte(8'h3C, 60);
    check(pulses == p0 + 1, "R3 frame after reset", pulses, p0 + 1);
    check(rx_data == 8'h3C, "R5 frame after reset data", int'(rx_data), 8'h3C);
    check(sent_q.size() == 0, "R3 queue drained", sent_q.size(), 0);

    report();
    $finish;
  end

endmodule